// File: doc/BRIEF.md
# Firmware Image Version Comparator

This block ranks a candidate firmware image header against a base header. It reports whether the candidate is incompatible with the base, older, equivalent or newer. Each header has three parts: a signature word, six version fields and a digest made of several words. The host places both headers on parallel inputs and pulses `start`. The block copies both headers into internal registers, so the inputs may change after the sampling edge.

Most outcomes are settled by a single ranking step on the captured fields. If patch, phase and build are all equal, the block instead walks the two digests one word per clock. It stops at the first word that differs. When the result is ready, `done` pulses for one cycle and the verdict appears. A separate flag reports whether the candidate's major number is usable.

Top module: `fw_hdr_ranker`

## Requirements
- R1: A `start` sampled while the block is idle captures both headers. The inputs may change after that edge without effect. When the full-tie case does not apply, `done` is high in the cycle after the first clock edge following the sampling edge.
- R2: The verdict is encoded as 0 = incompatible, 1 = older, 2 = same, 3 = better. `verdict` and `cand_valid` change only together with a `done` pulse and otherwise hold their value. After reset, both are 0 and `done` is low.
- R3: Each version input is packed with major in bits [47:40], minor in [39:32], maintenance in [31:24], patch in [23:16], phase in [15:8] and build in [7:0]. If the signature, major, minor or maintenance field differs between the headers, the verdict is 0.
- R4: If those fields match and the patch numbers differ, the verdict is 3 when the candidate patch is higher and 1 when it is lower.
- R5: A header counts as a release unless its phase and build fields are both zero. With equal patch numbers, a release base against a non-release candidate gives 1, and a non-release base against a release candidate gives 3.
- R6: With equal patch numbers and both headers releases, the verdict is 2 when phase or build differs. The digests are not compared in that case.
- R7: If patch, phase and build are all equal, the digests are compared word by word, with word i in bits [32i+31:32i]. If all eight words match, the verdict is 2 and `done` follows the sampling edge by 9 edges.
- R8: A digest mismatch gives verdict 0, and the walk stops at the first differing word k. `done` then follows the sampling edge by k+2 edges.
- R9: `cand_valid` is 0 when the candidate major number is 0x00 or 0xFF and 1 otherwise, whatever the verdict.
- R10: A `start` pulse while a comparison is running is ignored. It produces no extra result and does not alter the running result.
- R11: `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a comparison (sampled when idle) |
| base_sig | input | 32 | Base header signature |
| base_ver | input | 48 | Base version fields, major in the top byte |
| base_digest | input | 256 | Base digest, word 0 in the low bits |
| cand_sig | input | 32 | Candidate header signature |
| cand_ver | input | 48 | Candidate version fields |
| cand_digest | input | 256 | Candidate digest |
| done | output | 1 | One-cycle result strobe |
| verdict | output | 2 | Ranking result, held until the next result |
| cand_valid | output | 1 | Candidate major number is usable |

## Verification
The hardest case to reach is a `start` that arrives while the digest walk is in progress. The same applies to a mismatch that ends the walk at a chosen word. To set up the first case, the stimulus applies two headers whose patch, phase and build all tie, so the walk runs its full eight cycles. It then pulses `start` mid-walk with incompatible headers and changed inputs, and checks that exactly one result arrives on time with the first pair's verdict. For the second case, the stimulus flips a single bit in digest word 0, 3 or 7. The cycle on which `done` appears shows where the walk stopped.

// File: rtl/fwcmp_pkg.sv
package fwcmp_pkg;
  typedef enum logic [1:0] {
    VERD_INCOMP = 2'd0,
    VERD_OLD    = 2'd1,
    VERD_SAME   = 2'd2,
    VERD_BETTER = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RANK = 2'd1,
    ST_WALK = 2'd2
  } step_e;

  localparam int NUM_VER_FIELDS = 6;
  localparam int FLD_MAJOR = 0;
  localparam int FLD_MINOR = 1;
  localparam int FLD_MAINT = 2;
  localparam int FLD_PATCH = 3;
  localparam int FLD_PHASE = 4;
  localparam int FLD_BUILD = 5;
endpackage

// File: rtl/fwcmp_field_rank.sv
module fwcmp_field_rank
  import fwcmp_pkg::*;
#(
  parameter int SIG_W   = 32,
  parameter int FIELD_W = 8,
  localparam int VER_W  = NUM_VER_FIELDS * FIELD_W
) (
  input  logic [SIG_W-1:0] base_sig,
  input  logic [VER_W-1:0] base_ver,
  input  logic [SIG_W-1:0] cand_sig,
  input  logic [VER_W-1:0] cand_ver,
  output verdict_e         rank,
  output logic             need_digest
);
  logic [NUM_VER_FIELDS-1:0] fld_eq;
  logic [NUM_VER_FIELDS-1:0] fld_gt;

  // field k sits k fields below the top of the vector (major first)
  for (genvar k = 0; k < NUM_VER_FIELDS; k++) begin : g_fld
    localparam int HI = VER_W - 1 - k * FIELD_W;
    assign fld_eq[k] = (cand_ver[HI -: FIELD_W] == base_ver[HI -: FIELD_W]);
    assign fld_gt[k] = (cand_ver[HI -: FIELD_W] >  base_ver[HI -: FIELD_W]);
  end

  localparam int PH_HI = VER_W - 1 - FLD_PHASE * FIELD_W;
  localparam int BD_HI = VER_W - 1 - FLD_BUILD * FIELD_W;

  logic compat, low_tie, base_rel, cand_rel;

  assign compat   = (cand_sig == base_sig) & fld_eq[FLD_MAJOR]
                  & fld_eq[FLD_MINOR] & fld_eq[FLD_MAINT];
  assign low_tie  = fld_eq[FLD_PATCH] & fld_eq[FLD_PHASE] & fld_eq[FLD_BUILD];
  assign base_rel = (|base_ver[PH_HI -: FIELD_W]) | (|base_ver[BD_HI -: FIELD_W]);
  assign cand_rel = (|cand_ver[PH_HI -: FIELD_W]) | (|cand_ver[BD_HI -: FIELD_W]);

  always_comb begin
    rank        = VERD_INCOMP;
    need_digest = 1'b0;
    if (!compat) begin
      rank = VERD_INCOMP;
    end else if (low_tie) begin
      need_digest = 1'b1;
      rank        = VERD_SAME;
    end else if (!fld_eq[FLD_PATCH]) begin
      rank = fld_gt[FLD_PATCH] ? VERD_BETTER : VERD_OLD;
    end else if (base_rel && cand_rel) begin
      rank = VERD_SAME;
    end else if (base_rel) begin
      rank = VERD_OLD;
    end else begin
      // two non-release headers with equal patch are a full tie (handled above)
      rank = VERD_BETTER;
    end
  end
endmodule

// File: rtl/fwcmp_major_check.sv
module fwcmp_major_check #(
  parameter int FIELD_W = 8
) (
  input  logic [FIELD_W-1:0] major,
  output logic               usable
);
  assign usable = (major != '0) && (major != '1);
endmodule

// File: rtl/fwcmp_digest_walk.sv
module fwcmp_digest_walk #(
  parameter int DIG_WORDS  = 8,
  parameter int DIG_WORD_W = 32,
  localparam int DIG_W     = DIG_WORDS * DIG_WORD_W,
  localparam int IDX_W     = (DIG_WORDS > 1) ? $clog2(DIG_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             active,
  input  logic [DIG_W-1:0] base_dig,
  input  logic [DIG_W-1:0] cand_dig,
  output logic             mismatch,
  output logic             last
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = go | active;

  always_comb begin
    idx_d = idx_q;
    if (go)          idx_d = '0;
    else if (active) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign mismatch = base_dig[idx_q*DIG_WORD_W +: DIG_WORD_W]
                 != cand_dig[idx_q*DIG_WORD_W +: DIG_WORD_W];
  assign last     = (idx_q == IDX_W'(DIG_WORDS - 1));

  // R8: walk never runs past the last digest word
  a_r8_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/fw_hdr_ranker.sv
module fw_hdr_ranker
  import fwcmp_pkg::*;
#(
  parameter int SIG_W      = 32,
  parameter int FIELD_W    = 8,
  parameter int DIG_WORDS  = 8,
  parameter int DIG_WORD_W = 32,
  localparam int VER_W     = NUM_VER_FIELDS * FIELD_W,
  localparam int DIG_W     = DIG_WORDS * DIG_WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SIG_W-1:0] base_sig,
  input  logic [VER_W-1:0] base_ver,
  input  logic [DIG_W-1:0] base_digest,
  input  logic [SIG_W-1:0] cand_sig,
  input  logic [VER_W-1:0] cand_ver,
  input  logic [DIG_W-1:0] cand_digest,
  output logic             done,
  output logic [1:0]       verdict,
  output logic             cand_valid
);
  step_e            step_q, step_d;
  logic             cap_en;
  logic [SIG_W-1:0] b_sig_q, c_sig_q;
  logic [VER_W-1:0] b_ver_q, c_ver_q;
  logic [DIG_W-1:0] b_dig_q, c_dig_q;

  verdict_e verd_q, verd_d;
  logic     valid_q, done_q, done_d;
  logic     walk_go, walk_active;

  verdict_e rank;
  logic     need_digest, mismatch, last, major_ok;

  // capture stage
  assign cap_en = start && (step_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sig_q <= '0; c_sig_q <= '0;
      b_ver_q <= '0; c_ver_q <= '0;
      b_dig_q <= '0; c_dig_q <= '0;
    end else if (cap_en) begin
      b_sig_q <= base_sig;    c_sig_q <= cand_sig;
      b_ver_q <= base_ver;    c_ver_q <= cand_ver;
      b_dig_q <= base_digest; c_dig_q <= cand_digest;
    end
  end

  fwcmp_field_rank #(.SIG_W(SIG_W), .FIELD_W(FIELD_W)) u_rank (
    .base_sig    (b_sig_q),
    .base_ver    (b_ver_q),
    .cand_sig    (c_sig_q),
    .cand_ver    (c_ver_q),
    .rank        (rank),
    .need_digest (need_digest)
  );

  fwcmp_major_check #(.FIELD_W(FIELD_W)) u_major (
    .major  (c_ver_q[VER_W-1 -: FIELD_W]),
    .usable (major_ok)
  );

  fwcmp_digest_walk #(.DIG_WORDS(DIG_WORDS), .DIG_WORD_W(DIG_WORD_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (walk_go),
    .active   (walk_active),
    .base_dig (b_dig_q),
    .cand_dig (c_dig_q),
    .mismatch (mismatch),
    .last     (last)
  );

  // sequencing
  assign walk_active = (step_q == ST_WALK);

  always_comb begin
    step_d  = step_q;
    verd_d  = verd_q;
    done_d  = 1'b0;
    walk_go = 1'b0;
    case (step_q)
      ST_IDLE: if (start) step_d = ST_RANK;
      ST_RANK: begin
        if (need_digest) begin
          walk_go = 1'b1;
          step_d  = ST_WALK;
        end else begin
          verd_d = rank;
          done_d = 1'b1;
          step_d = ST_IDLE;
        end
      end
      ST_WALK: begin
        if (mismatch) begin
          verd_d = VERD_INCOMP;
          done_d = 1'b1;
          step_d = ST_IDLE;
        end else if (last) begin
          verd_d = VERD_SAME;
          done_d = 1'b1;
          step_d = ST_IDLE;
        end
      end
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verd_q  <= VERD_INCOMP;
      valid_q <= 1'b0;
    end else if (done_d) begin
      verd_q  <= verd_d;
      valid_q <= major_ok;
    end
  end

  assign done       = done_q;
  assign verdict    = verd_q;
  assign cand_valid = valid_q;

  // R11: strobe lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2: outputs only move with a result
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(verd_q) && $stable(valid_q)));
  // R10: captured headers frozen while busy
  a_r10_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != ST_IDLE) |=> ($stable(b_sig_q) && $stable(c_ver_q) && $stable(c_dig_q)));
  // R8: a differing digest word ends the walk as incompatible
  a_r8_stop_incomp: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_active && mismatch) |=> (done_q && verd_q == VERD_INCOMP));
  // R1: a result always follows a busy cycle
  a_r1_done_after_work: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(step_q) != ST_IDLE));
endmodule

// File: tb/sim_fw_hdr_ranker.sv
module sim_fw_hdr_ranker;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0] v;
    logic       ok;
    int         due;
    string      req;
  } exp_t;

  logic         clk, rst_n, start;
  logic [31:0]  base_sig, cand_sig;
  logic [47:0]  base_ver, cand_ver;
  logic [255:0] base_digest, cand_digest;
  logic         done, cand_valid;
  logic [1:0]   verdict;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  logic prev_done = 1'b0;
  exp_t q[$];

  fw_hdr_ranker u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mkver(input int mj, mn, mt, pa, ph, bd);
    return {mj[7:0], mn[7:0], mt[7:0], pa[7:0], ph[7:0], bd[7:0]};
  endfunction

  function automatic logic [255:0] mkdig(input int seed);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = 32'hA5000000 + seed + i * 32'h01010101;
    return d;
  endfunction

  // monitor: pops expected items when results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        chk(!prev_done, "R11", "done width", 2, 1);
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(verdict == e.v, e.req, "verdict", verdict, e.v);
          chk(cand_valid == e.ok, e.req, "cand_valid", cand_valid, e.ok);
          chk(cyc == e.due, e.req, "result cycle", cyc, e.due);
        end
      end
      prev_done = done;
    end
  end

  task automatic launch(input logic [31:0] bs, input logic [47:0] bv, input logic [255:0] bd,
                        input logic [31:0] cs, input logic [47:0] cv, input logic [255:0] cd,
                        input logic [1:0] ev, input logic eok, input int lat, input string req);
    exp_t e;
    @(negedge clk);
    base_sig = bs; base_ver = bv; base_digest = bd;
    cand_sig = cs; cand_ver = cv; cand_digest = cd;
    start = 1'b1;
    @(posedge clk); #1;
    e.v = ev; e.ok = eok; e.due = cyc + lat; e.req = req;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R1", "result missing", q.size(), 0);
    q.delete();
    @(negedge clk);
  endtask

  task automatic vec(input logic [47:0] bv, input logic [47:0] cv,
                     input logic [255:0] cd, input logic [1:0] ev,
                     input logic eok, input int lat, input string req);
    launch(32'h1234_5678, bv, mkdig(0), 32'h1234_5678, cv, cd, ev, eok, lat, req);
    drain();
  endtask

  initial begin
    logic [255:0] d0;
    logic [1:0]   held_v;
    d0 = mkdig(0);
    start = 1'b0; rst_n = 1'b0;
    base_sig = '0; cand_sig = '0; base_ver = '0; cand_ver = '0;
    base_digest = '0; cand_digest = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R2", "reset done", done, 0);
    chk(verdict == 2'd0, "R2", "reset verdict", verdict, 0);
    chk(cand_valid == 1'b0, "R2", "reset cand_valid", cand_valid, 0);

    // R3: compatibility fields
    launch(32'h1234_5678, mkver(2,3,1,5,0,0), d0, 32'h1234_5679, mkver(2,3,1,5,0,0), d0,
           2'd0, 1'b1, 1, "R3"); drain();
    vec(mkver(2,3,1,5,0,0), mkver(2,4,1,5,0,0), d0, 2'd0, 1'b1, 1, "R3");
    vec(mkver(2,3,1,5,0,0), mkver(2,3,0,5,0,0), d0, 2'd0, 1'b1, 1, "R3");
    // R4: patch ordering
    vec(mkver(2,3,1,5,0,0), mkver(2,3,1,6,0,0), d0, 2'd3, 1'b1, 1, "R4");
    vec(mkver(2,3,1,5,9,9), mkver(2,3,1,4,9,9), d0, 2'd1, 1'b1, 1, "R4");
    // R5: release versus internal build
    vec(mkver(2,3,1,5,1,0), mkver(2,3,1,5,0,0), d0, 2'd1, 1'b1, 1, "R5");
    vec(mkver(2,3,1,5,0,0), mkver(2,3,1,5,0,4), d0, 2'd3, 1'b1, 1, "R5");
    // R6: two releases, different build, digests differ but are not examined
    vec(mkver(2,3,1,5,1,2), mkver(2,3,1,5,1,3), mkdig(7), 2'd2, 1'b1, 1, "R6");
    // R7: full ties walk the digest
    vec(mkver(2,3,1,5,0,0), mkver(2,3,1,5,0,0), d0, 2'd2, 1'b1, 9, "R7");
    vec(mkver(2,3,1,5,2,7), mkver(2,3,1,5,2,7), d0, 2'd2, 1'b1, 9, "R7");
    // R8: early stop at the first bad word
    vec(mkver(2,3,1,5,0,0), mkver(2,3,1,5,0,0), d0 ^ (256'h1 << 3), 2'd0, 1'b1, 2, "R8");
    vec(mkver(2,3,1,5,0,0), mkver(2,3,1,5,0,0), d0 ^ (256'h1 << (3*32+5)), 2'd0, 1'b1, 5, "R8");
    vec(mkver(2,3,1,5,0,0), mkver(2,3,1,5,0,0), d0 ^ (256'h1 << (7*32+31)), 2'd0, 1'b1, 9, "R8");
    // R9: unusable major numbers
    vec(mkver(0,3,1,5,0,0), mkver(0,3,1,6,0,0), d0, 2'd3, 1'b0, 1, "R9");
    vec(mkver(255,3,1,5,0,0), mkver(255,3,1,4,0,0), d0, 2'd1, 1'b0, 1, "R9");
    vec(mkver(2,3,1,5,0,0), mkver(255,3,1,5,0,0), d0, 2'd0, 1'b0, 1, "R9");

    // R10 and R1: a second start during the walk, with inputs changed
    launch(32'h1234_5678, mkver(2,3,1,5,0,0), d0, 32'h1234_5678, mkver(2,3,1,5,0,0), d0,
           2'd2, 1'b1, 9, "R10");
    repeat (2) @(negedge clk);
    cand_sig = 32'hDEAD_BEEF; cand_ver = mkver(0,0,0,0,0,0); cand_digest = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (12) @(negedge clk);

    // R2: outputs hold with no strobe
    held_v = verdict;
    repeat (6) @(negedge clk);
    chk(verdict == held_v, "R2", "held verdict", verdict, held_v);
    chk(cand_valid == 1'b1, "R2", "held cand_valid", cand_valid, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule